// File: doc/BRIEF.md
# Per-Block Write Lock Controller

This block keeps a lock bit and a lock-down bit for each of a small set of memory blocks. Based on those bits it decides whether a program or erase aimed at a given block may proceed. Lock commands arrive as a two-cycle byte sequence on a write port. A setup byte arms the sequencer. The next byte picks lock, unlock or lock-down for the block index presented with that byte. A byte that is not a valid confirm raises a sticky sequence-error flag.

A write-protect override pin lets software unlock a locked-down block. When the pin drops again, every locked-down block is re-locked. Lock-down itself is cleared only by reset. A per-block fuse input marks blocks that are permanently locked, whatever the pin does. A permit query returns its answer in the same cycle. A denied query raises a sticky lock-error flag. A status port returns two bits for any chosen block.

Top module: `blklk_ctrl`

## Requirements
- R1: After reset every block's lock bit is 1, every lock-down bit is 0, and both error flags are 0.
- R2: The setup byte 60h followed by the confirm byte 01h locks the block given with the confirm byte. Setup followed by 2Fh sets both the lock bit and the lock-down bit of that block.
- R3: Setup followed by D0h clears the lock bit of the given block, unless R6 or R8 forbids it.
- R4: When the byte after setup is not 01h, D0h or 2Fh, `seq_err` goes to 1 one cycle later and no block changes. The sequencer then expects a new setup byte.
- R5: A confirm byte that does not follow a setup byte has no effect on any block.
- R6: While `wp` is 0, an unlock aimed at a locked-down block is ignored. While `wp` is 1, the unlock is honoured and the lock-down bit stays set.
- R7: Only reset clears a lock-down bit. A 1-to-0 transition of `wp` sets the lock bit of every locked-down block at the next clock edge.
- R8: A block whose `otp_fuse` bit is 1 always reads as locked and cannot be unlocked, even with `wp` at 1.
- R9: `op_ok` is 1 in the same cycle exactly when the block on `op_blk` is not locked. A query with `op_req` at 1 that is denied sets `lock_err` at the next edge.
- R10: A pulse on `err_clr` clears `seq_err` and `lock_err`.
- R11: `stat_bits` for block `stat_blk` is {lock-down bit, effective lock}, where the effective lock is the lock bit OR'd with the fuse bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command byte valid |
| wr_data | input | 8 | Command byte |
| wr_blk | input | BW | Block index sampled with the confirm byte |
| wp | input | 1 | Write-protect override, 1 = lock-down may be bypassed |
| otp_fuse | input | NBLK | Permanent lock per block |
| op_req | input | 1 | Program/erase permit query |
| op_blk | input | BW | Block targeted by the query |
| op_ok | output | 1 | Query permitted |
| stat_blk | input | BW | Block whose status is shown |
| stat_bits | output | 2 | {lock-down, effective lock} |
| err_clr | input | 1 | Clear both error flags |
| seq_err | output | 1 | Sticky bad-sequence flag |
| lock_err | output | 1 | Sticky denied-operation flag |

## Verification
Directed sequences come first. They exercise the basic cases: a confirm byte with no setup, a junk confirm, and an unlock of a locked-down block with the pin low and then high. They also cover a pin fall that re-locks the block, an unlock attempt on a fused block, and a reset that must clear lock-down. Together these separate the pin override from the fuse and from reset. A seeded random phase then mixes full sequences, lone bytes, pin toggles, queries and flag clears. This finds mistakes in the ordering between the sequencer state, the pin history and per-block state, which the directed cases would not reach.

// File: rtl/blklk_pkg.sv
package blklk_pkg;

  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK   = 8'h01;
  localparam logic [7:0] CMD_UNLOCK = 8'hD0;
  localparam logic [7:0] CMD_LDOWN  = 8'h2F;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_LDOWN  = 2'd3
  } lk_op_e;

  // Map the byte following setup to an action; OP_NONE marks a bad confirm.
  function automatic lk_op_e decode_confirm(input logic [7:0] b);
    case (b)
      CMD_LOCK:   return OP_LOCK;
      CMD_UNLOCK: return OP_UNLOCK;
      CMD_LDOWN:  return OP_LDOWN;
      default:    return OP_NONE;
    endcase
  endfunction

  // Unlock is refused on fused blocks, and on locked-down blocks unless overridden.
  function automatic logic unlock_allowed(input logic ldn, input logic otp,
                                          input logic wp);
    return !otp && (!ldn || wp);
  endfunction

endpackage

// File: rtl/blklk_seq.sv
module blklk_seq
  import blklk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       cmd_fire,
  output lk_op_e     cmd_op,
  output logic       bad_confirm
);

  logic   armed;
  lk_op_e conf_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (wr_valid) begin
      armed <= armed ? 1'b0 : (wr_data == CMD_SETUP);
    end
  end

  always_comb begin
    conf_op     = decode_confirm(wr_data);
    cmd_op      = conf_op;
    cmd_fire    = wr_valid && armed && (conf_op != OP_NONE);
    bad_confirm = wr_valid && armed && (conf_op == OP_NONE);
  end

endmodule

// File: rtl/blklk_cell.sv
module blklk_cell
  import blklk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel,
  input  lk_op_e op,
  input  logic   wp,
  input  logic   wp_fall,
  input  logic   otp,
  output logic   lock_q,
  output logic   ldn_q
);

  logic lock_n, ldn_n;

  always_comb begin
    lock_n = lock_q;
    ldn_n  = ldn_q;
    if (sel) begin
      case (op)
        OP_LOCK:   lock_n = 1'b1;
        OP_LDOWN:  begin lock_n = 1'b1; ldn_n = 1'b1; end
        OP_UNLOCK: if (unlock_allowed(ldn_q, otp, wp)) lock_n = 1'b0;
        default:   ;
      endcase
    end
    if (wp_fall && ldn_n) lock_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      ldn_q  <= 1'b0;
    end else begin
      lock_q <= lock_n;
      ldn_q  <= ldn_n;
    end
  end

endmodule

// File: rtl/blklk_ctrl.sv
module blklk_ctrl
  import blklk_pkg::*;
#(
  parameter  int NBLK = 16,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [7:0]      wr_data,
  input  logic [BW-1:0]   wr_blk,
  input  logic            wp,
  input  logic [NBLK-1:0] otp_fuse,
  input  logic            op_req,
  input  logic [BW-1:0]   op_blk,
  output logic            op_ok,
  input  logic [BW-1:0]   stat_blk,
  output logic [1:0]      stat_bits,
  input  logic            err_clr,
  output logic            seq_err,
  output logic            lock_err
);

  logic [NBLK-1:0] lock_vec, ldn_vec, eff_lock;
  logic            wp_q, wp_fall;
  logic            cmd_fire, bad_confirm, deny_evt;
  lk_op_e          cmd_op;

  blklk_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .cmd_fire    (cmd_fire),
    .cmd_op      (cmd_op),
    .bad_confirm (bad_confirm)
  );

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    blklk_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (cmd_fire && (wr_blk == BW'(g))),
      .op      (cmd_op),
      .wp      (wp),
      .wp_fall (wp_fall),
      .otp     (otp_fuse[g]),
      .lock_q  (lock_vec[g]),
      .ldn_q   (ldn_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wp_q <= 1'b0;
    else        wp_q <= wp;
  end

  always_comb begin
    wp_fall   = wp_q && !wp;
    eff_lock  = lock_vec | otp_fuse;
    op_ok     = !eff_lock[op_blk];
    deny_evt  = op_req && !op_ok;
    stat_bits = {ldn_vec[stat_blk], eff_lock[stat_blk]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_err  <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      seq_err  <= (seq_err  && !err_clr) || bad_confirm;
      lock_err <= (lock_err && !err_clr) || deny_evt;
    end
  end

endmodule

// File: rtl/blklk_ctrl_chk.sv
module blklk_ctrl_chk
  import blklk_pkg::*;
#(
  parameter  int NBLK = 16,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [BW-1:0]   wr_blk,
  input logic            wp,
  input logic [NBLK-1:0] otp_fuse,
  input logic            op_req,
  input logic            op_ok,
  input logic            seq_err,
  input logic            lock_err,
  input logic [NBLK-1:0] lock_vec,
  input logic [NBLK-1:0] ldn_vec,
  input logic            cmd_fire,
  input lk_op_e          cmd_op,
  input logic            bad_confirm
);

  AST_BAD_CONFIRM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad_confirm |=> seq_err); // R4

  AST_LDOWN_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == OP_LDOWN) |=> (ldn_vec[$past(wr_blk)] && lock_vec[$past(wr_blk)])); // R2

  AST_LDN_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ldn_vec & lock_vec) & ~lock_vec)) |-> $past(wp)); // R6

  AST_LDN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ldn_vec) & ~ldn_vec) == '0)); // R7

  AST_WP_FALL_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp) |=> ((ldn_vec & ~lock_vec) == '0)); // R7

  AST_OTP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(otp_fuse & lock_vec) & ~lock_vec) == '0)); // R8

  AST_DENY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_ok) |=> lock_err); // R9

endmodule

bind blklk_ctrl blklk_ctrl_chk #(.NBLK(NBLK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_blk      (wr_blk),
  .wp          (wp),
  .otp_fuse    (otp_fuse),
  .op_req      (op_req),
  .op_ok       (op_ok),
  .seq_err     (seq_err),
  .lock_err    (lock_err),
  .lock_vec    (lock_vec),
  .ldn_vec     (ldn_vec),
  .cmd_fire    (cmd_fire),
  .cmd_op      (cmd_op),
  .bad_confirm (bad_confirm)
);

// File: tb/blklk_ctrl_tb.sv
`timescale 1ns/1ps
module blklk_ctrl_tb;

  localparam int NBLK = 16;

  logic        clk = 1'b0, rst_n = 1'b0, wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  wr_blk = '0, op_blk = '0, stat_blk = '0;
  logic        wp = 1'b0, op_req = 1'b0, err_clr = 1'b0;
  logic [15:0] otp_fuse = 16'h0082;
  logic        op_ok, seq_err, lock_err;
  logic [1:0]  stat_bits;

  bit m_lock[NBLK], m_ldn[NBLK];
  bit m_armed, m_seq, m_lerr, m_wp;
  int n_chk = 0, n_fail = 0;

  blklk_ctrl #(.NBLK(NBLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_blk(wr_blk), .wp(wp), .otp_fuse(otp_fuse), .op_req(op_req),
    .op_blk(op_blk), .op_ok(op_ok), .stat_blk(stat_blk),
    .stat_bits(stat_bits), .err_clr(err_clr), .seq_err(seq_err),
    .lock_err(lock_err)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < NBLK; i++) begin m_lock[i] = 1; m_ldn[i] = 0; end
    m_armed = 0; m_seq = 0; m_lerr = 0;
  endfunction

  function automatic void m_apply(input logic [7:0] d, input int b);
    if (!m_armed) begin
      m_armed = (d == 8'h60);
    end else begin
      m_armed = 0;
      if (d == 8'h01) m_lock[b] = 1;
      else if (d == 8'h2F) begin m_lock[b] = 1; m_ldn[b] = 1; end
      else if (d == 8'hD0) begin
        if (!otp_fuse[b] && (!m_ldn[b] || m_wp)) m_lock[b] = 0;
      end else m_seq = 1;
    end
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  task automatic wr(input logic [7:0] d, input int b);
    @(negedge clk) begin wr_valid = 1; wr_data = d; wr_blk = 4'(b); end
    @(posedge clk); #1 wr_valid = 0;
    m_apply(d, b);
  endtask

  task automatic set_wp(input bit v);
    @(negedge clk) wp = v;
    @(posedge clk); #1;
    if (m_wp && !v)
      for (int i = 0; i < NBLK; i++) if (m_ldn[i]) m_lock[i] = 1;
    m_wp = v;
  endtask

  task automatic chk_blk(input int b, input string req);
    logic [1:0] e;
    @(negedge clk) stat_blk = 4'(b);
    #1 e = {m_ldn[b], m_lock[b] | otp_fuse[b]};
    chk(stat_bits == e, req, stat_bits, e);
  endtask

  task automatic chk_flags(input string req);
    #1;
    chk(seq_err == m_seq, req, seq_err, m_seq);
    chk(lock_err == m_lerr, req, lock_err, m_lerr);
  endtask

  task automatic query(input int b);
    bit e;
    @(negedge clk) begin op_req = 1; op_blk = 4'(b); end
    #1 e = !(m_lock[b] | otp_fuse[b]);
    chk(op_ok == e, "R9", op_ok, e);
    @(posedge clk); #1 op_req = 0;
    if (!e) m_lerr = 1;
    chk(lock_err == m_lerr, "R9", lock_err, m_lerr);
  endtask

  task automatic clr();
    @(negedge clk) err_clr = 1;
    @(posedge clk); #1 err_clr = 0;
    m_seq = 0; m_lerr = 0;
    chk_flags("R10");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_wp = 0;
    do_reset();
    for (int b = 0; b < NBLK; b++) chk_blk(b, "R1");
    chk_flags("R1");

    wr(8'hD0, 2);               chk_blk(2, "R5");
    wr(8'h60, 3); wr(8'hD0, 3); chk_blk(3, "R3");
    query(3);
    query(4);
    clr();

    wr(8'h60, 6); wr(8'hFF, 6);
    #1 chk(seq_err == 1'b1, "R4", seq_err, 1);
    chk_blk(6, "R4");
    wr(8'hD0, 6); chk_blk(6, "R4");
    clr();

    wr(8'h60, 8); wr(8'hD0, 8); wr(8'h60, 8); wr(8'h01, 8); chk_blk(8, "R2");
    wr(8'h60, 5); wr(8'h2F, 5); chk_blk(5, "R2");
    wr(8'h60, 5); wr(8'hD0, 5); chk_blk(5, "R6");
    set_wp(1);
    wr(8'h60, 5); wr(8'hD0, 5); chk_blk(5, "R6");
    query(5);
    set_wp(0);                  chk_blk(5, "R7");
    do_reset();                 chk_blk(5, "R7");

    set_wp(1);
    wr(8'h60, 7); wr(8'hD0, 7); chk_blk(7, "R8");
    query(7);
    chk_blk(1, "R8");
    set_wp(0);
    clr();

    for (int it = 0; it < 700; it++) begin
      int r, b, k;
      r = $urandom_range(0, 9);
      b = $urandom_range(0, NBLK - 1);
      case (r)
        0, 1, 2, 3: begin
          k = $urandom_range(0, 4);
          wr(8'h60, b);
          wr(k == 0 ? 8'h01 : k == 1 ? 8'h2F : k == 4 ? 8'($urandom) : 8'hD0, b);
        end
        4: wr(8'($urandom), b);
        5: set_wp(1'($urandom_range(0, 1)));
        6, 7: query(b);
        8: clr();
        default: ;
      endcase
      chk_blk($urandom_range(0, NBLK - 1), "R11");
      chk_flags("R4");
    end
    summary();
  end

endmodule